// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 256K bytes. A requester presents one transfer at a time on a valid/ready handshake: a direction bit, an 18-bit word address and, for writes, one data byte. The controller turns each transfer into a correctly timed strobe sequence on the memory pins. It drives a low-active select, a high-active select, a low-active write strobe, a low-active output strobe and the address. It also drives the outbound half of a split data bus with its own enable, so the tri-state pad itself can sit in the pad ring. Read data returns with a one-cycle valid pulse.

Every memory timing minimum is a parameter in picoseconds. The controller converts each one into a whole number of clock cycles, rounding up, so a change of clock period or speed grade needs only new parameter values. A write is timed by the window in which both selects and the write strobe are active. The controller closes that window by releasing all three strobes on one clock edge. The pulse length is set so that address setup, strobe width and data setup, all measured back from that closing edge, are met. After a read, the output strobe stays high for a turnaround gap before the controller may drive the bus again.

States: `ST_IDLE` (memory deselected, request accepted), `ST_READ` (selects and output strobe active), `ST_RTURN` (deselected, waiting for the memory to release the bus), `ST_WRITE` (selects and write strobe active, bus driven), `ST_WREC` (deselected, filling out the write cycle). Transitions: IDLE→READ on a read request; IDLE→WRITE on a write request; READ→RTURN when the read count ends; RTURN→IDLE when the turnaround count ends; WRITE→WREC when the pulse count ends; WREC→IDLE when the recovery count ends.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the memory is deselected (mem_sel_n=1, mem_sel_p=0), mem_wstb_n=1, mem_ostb_n=1, mem_dq_en=0, rd_valid=0 and req_ready=1.
- R2: A read holds mem_sel_n=0, mem_sel_p=1, mem_ostb_n=0 and mem_wstb_n=1 with a stable address for RD_CYC = ceil(max(read cycle, address access, output-strobe access)/clock) cycles. The write strobe and output strobe are never low together.
- R3: The byte on mem_dq_i in the last read cycle is returned on rd_data with a rd_valid pulse of exactly one cycle. Counting the cycle right after the accepting edge as cycle 1, rd_valid is high in cycle RD_CYC+1.
- R4: A write holds both selects active and mem_wstb_n=0 for WP_CYC = ceil(max(strobe width, address setup to end, data setup to end)/clock) cycles, with address and data stable. mem_dq_en is high only while mem_wstb_n=0, mem_ostb_n=1 and the memory is selected.
- R5: A write ends by releasing mem_wstb_n, both selects and mem_dq_en on the same edge. req_ready returns in cycle WP_CYC+WREC_CYC+1, where WREC_CYC = max(1, ceil(write cycle/clock) - WP_CYC).
- R6: After a read, the memory stays deselected with mem_ostb_n=1 for TURN_CYC = max(1, ceil(output-release time/clock)) cycles. req_ready returns in cycle RD_CYC+TURN_CYC+1, and mem_dq_en is never high in the cycle after mem_ostb_n was low.
- R7: A request is accepted only while req_ready is high, which holds only in ST_IDLE with the memory deselected. A request held during a busy transfer starts no memory access and produces no rd_valid.
- R8: Data written to any address, including 0x00000 and 0x3FFFF, reads back unchanged, through back-to-back mixed transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, rd_data valid |
| rd_data | output | 8 | Read byte |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_sel_p | output | 1 | Memory select, active high |
| mem_wstb_n | output | 1 | Write strobe, active low |
| mem_ostb_n | output | 1 | Output strobe, active low |
| mem_addr | output | 18 | Memory address |
| mem_dq_o | output | 8 | Outbound data to the pad |
| mem_dq_en | output | 1 | Pad output enable |
| mem_dq_i | input | 8 | Inbound data from the pad |

## Verification
The bench builds the controller with a 5000 ps clock parameter and the default 70 ns grade timings. This yields RD_CYC=14, WP_CYC=12, WREC_CYC=2 and TURN_CYC=5, so the recovery count takes more than its one-cycle floor and every counter runs through a multi-cycle window. Its behavioural memory returns a junk byte until the address and output strobe have been held for the access time. It also tracks how long the memory has been off the bus, so a read or turnaround one cycle short shows up as wrong data or a contention count.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_RTURN = 3'd2,
        ST_WRITE = 3'd3,
        ST_WREC  = 3'd4
    } ctrl_state_t;

    // whole clock cycles covering a time in picoseconds
    function automatic int ceil_cyc(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 4,
    parameter int RD_CYC   = 7,
    parameter int WP_CYC   = 6,
    parameter int WREC_CYC = 1,
    parameter int TURN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              mem_sel_n,
    output logic              mem_sel_p,
    output logic              mem_wstb_n,
    output logic              mem_ostb_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_en,
    input  logic [DATA_W-1:0] mem_dq_i
);
    ctrl_state_t state_q, state_d;
    logic        accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    // next state and counter load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WRITE;
                        tmr_val = CNT_W'(WP_CYC - 1);
                    end else begin
                        state_d = ST_READ;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    state_d  = ST_RTURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_RTURN: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (tmr_done) begin
                    state_d  = ST_WREC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WREC_CYC - 1);
                end
            end
            ST_WREC: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered pin and response outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_sel_n  <= 1'b1;
            mem_sel_p  <= 1'b0;
            mem_wstb_n <= 1'b1;
            mem_ostb_n <= 1'b1;
            mem_dq_en  <= 1'b0;
            mem_addr   <= '0;
            mem_dq_o   <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            mem_sel_n  <= !((state_d == ST_READ) || (state_d == ST_WRITE));
            mem_sel_p  <=   (state_d == ST_READ) || (state_d == ST_WRITE);
            mem_wstb_n <= (state_d != ST_WRITE);
            mem_ostb_n <= (state_d != ST_READ);
            mem_dq_en  <= (state_d == ST_WRITE);
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_wdata;
            end
            rd_valid <= (state_q == ST_READ) && tmr_done;
            if ((state_q == ST_READ) && tmr_done) rd_data <= mem_dq_i;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 10000,
    parameter int T_RC_PS   = 70000,
    parameter int T_AA_PS   = 70000,
    parameter int T_DOE_PS  = 35000,
    parameter int T_HZOE_PS = 25000,
    parameter int T_WC_PS   = 70000,
    parameter int T_PWE_PS  = 45000,
    parameter int T_AW_PS   = 60000,
    parameter int T_SD_PS   = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_sel_n,
    output logic              mem_sel_p,
    output logic              mem_wstb_n,
    output logic              mem_ostb_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_en,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RD_CYC   = max2(1, max2(ceil_cyc(T_RC_PS, CLK_PS),
                                     max2(ceil_cyc(T_AA_PS, CLK_PS), ceil_cyc(T_DOE_PS, CLK_PS))));
    localparam int WP_CYC   = max2(1, max2(ceil_cyc(T_PWE_PS, CLK_PS),
                                     max2(ceil_cyc(T_AW_PS, CLK_PS), ceil_cyc(T_SD_PS, CLK_PS))));
    localparam int WREC_CYC = max2(1, ceil_cyc(T_WC_PS, CLK_PS) - WP_CYC);
    localparam int TURN_CYC = max2(1, ceil_cyc(T_HZOE_PS, CLK_PS));
    localparam int MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(WREC_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctrl_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .WREC_CYC (WREC_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .mem_sel_n  (mem_sel_n),
        .mem_sel_p  (mem_sel_p),
        .mem_wstb_n (mem_wstb_n),
        .mem_ostb_n (mem_ostb_n),
        .mem_addr   (mem_addr),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_en  (mem_dq_en),
        .mem_dq_i   (mem_dq_i)
    );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              mem_sel_n,
    input logic              mem_sel_p,
    input logic              mem_wstb_n,
    input logic              mem_ostb_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_en
);
    // R2: never both strobes low
    assert_no_dual_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_wstb_n && !mem_ostb_n));

    // R3: read-valid lasts one cycle
    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R4: bus driven only inside a selected write window
    assert_bus_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_en |-> (!mem_wstb_n && mem_ostb_n && !mem_sel_n && mem_sel_p));

    // R4: address and data steady while the write strobe stays low
    assert_wr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wstb_n && $past(!mem_wstb_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    // R5: write strobe, selects and drive drop together
    assert_wr_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wstb_n) |-> (mem_sel_n && !mem_sel_p && !mem_dq_en));

    // R6: no drive right after the output strobe was low
    assert_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_ostb_n) |-> !mem_dq_en);

    // R7: idle means deselected, and an accepted request leaves idle
    assert_idle_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel_p && mem_wstb_n && mem_ostb_n && !mem_dq_en));

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_sel_n  (mem_sel_n),
    .mem_sel_p  (mem_sel_p),
    .mem_wstb_n (mem_wstb_n),
    .mem_ostb_n (mem_ostb_n),
    .mem_addr   (mem_addr),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_en  (mem_dq_en)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
    localparam int CLK_PS = 5000;
    // expected cycle counts worked out from the ns figures at 5 ns
    localparam int RD_EXP   = 14;  // 70 ns access
    localparam int WP_EXP   = 12;  // 60 ns address setup to write end
    localparam int WREC_EXP = 2;   // 70 ns cycle - 60 ns pulse
    localparam int TURN_EXP = 5;   // 25 ns output release
    localparam int HZ_EXP   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        mem_sel_n, mem_sel_p, mem_wstb_n, mem_ostb_n, mem_dq_en;
    logic [17:0] mem_addr;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = 8'hEE;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2500 clk = ~clk;

    sram_async_ctrl #(.CLK_PS(CLK_PS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_sel_n(mem_sel_n), .mem_sel_p(mem_sel_p),
        .mem_wstb_n(mem_wstb_n), .mem_ostb_n(mem_ostb_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_en(mem_dq_en),
        .mem_dq_i(mem_dq_i)
    );

    // behavioural memory and bus monitor, sampled at the falling edge
    logic [7:0]  mem [int];
    int          wcnt = 0, rcnt = 0, rel_cnt = 100;
    int          last_pulse = 0, wr_ops = 0, rd_ops = 0;
    int          wr_unstable = 0, bad_drive = 0, rd_valid_seen = 0;
    logic [17:0] waddr = '0, raddr = '0;
    logic [7:0]  wdata = '0;

    function automatic logic [7:0] peek(input logic [17:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'h00;
    endfunction

    always @(negedge clk) begin
        logic wr_act, rd_act;
        wr_act = !mem_sel_n && mem_sel_p && !mem_wstb_n;
        rd_act = !mem_sel_n && mem_sel_p && !mem_ostb_n && mem_wstb_n;
        if (wr_act) begin
            if (wcnt == 0) begin
                waddr = mem_addr;
                wdata = mem_dq_o;
            end else if (waddr != mem_addr || wdata != mem_dq_o) begin
                wr_unstable++;
            end
            wcnt++;
        end else if (wcnt != 0) begin
            mem[int'(waddr)] = wdata;
            last_pulse = wcnt;
            wr_ops++;
            wcnt = 0;
        end
        if (rd_act) begin
            if (rcnt == 0) begin
                rd_ops++;
                raddr = mem_addr;
                rcnt = 1;
            end else if (raddr != mem_addr) begin
                raddr = mem_addr;
                rcnt = 1;
            end else begin
                rcnt++;
            end
            rel_cnt = 0;
        end else begin
            rcnt = 0;
            if (rel_cnt < 100) rel_cnt++;
        end
        mem_dq_i = (rcnt >= RD_EXP) ? peek(raddr) : 8'hEE;
        if (mem_dq_en && (!mem_ostb_n || mem_wstb_n || (rel_cnt - 1) < HZ_EXP)) bad_drive++;
        if (rd_valid) rd_valid_seen++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one transfer; latencies counted in falling edges after the accepting edge
    task automatic do_op(input logic wr, input logic [17:0] a, input logic [7:0] d,
                         output int lat_valid, output int lat_ready, output logic [7:0] rdat);
        int n;
        lat_valid = 0;
        lat_ready = 0;
        rdat = '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (n < 200) begin
            if (rd_valid) begin
                lat_valid = n;
                rdat = rd_data;
            end
            if (req_ready) begin
                lat_ready = n;
                break;
            end
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(mem_sel_n && !mem_sel_p, "R1 select idle", {mem_sel_n, mem_sel_p}, 2'b10);
        check(mem_wstb_n && mem_ostb_n, "R1 strobes high", {mem_wstb_n, mem_ostb_n}, 2'b11);
        check(!mem_dq_en && !rd_valid, "R1 no drive/valid", {mem_dq_en, rd_valid}, 0);
        check(req_ready, "R1 ready", req_ready, 1);
    endtask

    task automatic t_write_read;
        int lv, lr;
        logic [7:0] rd;
        int ops0;
        ops0 = wr_ops;
        do_op(1'b1, 18'h00012, 8'hA5, lv, lr, rd);
        check(last_pulse == WP_EXP, "R4 write pulse cycles", last_pulse, WP_EXP);
        check(wr_unstable == 0, "R4 write addr/data stable", wr_unstable, 0);
        check(lr == WP_EXP + WREC_EXP + 1, "R5 write ready latency", lr, WP_EXP + WREC_EXP + 1);
        check(wr_ops == ops0 + 1, "R5 write committed once", wr_ops - ops0, 1);
        do_op(1'b0, 18'h00012, 8'h00, lv, lr, rd);
        check(rd == 8'hA5, "R2 read data after full access", rd, 8'hA5);
        check(lv == RD_EXP + 1, "R3 read valid latency", lv, RD_EXP + 1);
        check(lr == RD_EXP + TURN_EXP + 1, "R6 read ready latency", lr, RD_EXP + TURN_EXP + 1);
    endtask

    task automatic t_pulse;
        int seen0, lv, lr;
        logic [7:0] rd;
        seen0 = rd_valid_seen;
        do_op(1'b0, 18'h00012, 8'h00, lv, lr, rd);
        check(rd_valid_seen - seen0 == 1, "R3 single valid pulse", rd_valid_seen - seen0, 1);
    endtask

    task automatic t_boundary;
        int lv, lr;
        logic [7:0] rd;
        do_op(1'b1, 18'h00000, 8'hFF, lv, lr, rd);
        do_op(1'b1, 18'h3FFFF, 8'h00, lv, lr, rd);
        do_op(1'b1, 18'h3FFFE, 8'h5A, lv, lr, rd);
        do_op(1'b0, 18'h00000, 8'h00, lv, lr, rd);
        check(rd == 8'hFF, "R8 low address", rd, 8'hFF);
        do_op(1'b0, 18'h3FFFF, 8'h00, lv, lr, rd);
        check(rd == 8'h00, "R8 top address", rd, 8'h00);
        do_op(1'b0, 18'h3FFFE, 8'h00, lv, lr, rd);
        check(rd == 8'h5A, "R8 next to top", rd, 8'h5A);
    endtask

    task automatic t_mixed;
        int lv, lr, errs;
        logic [7:0] rd;
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            do_op(1'b1, 18'(i * 18'h04321 + 18'h00100), 8'(8'h11 * i + 8'h3C), lv, lr, rd);
            do_op(1'b0, 18'(i * 18'h04321 + 18'h00100), 8'h00, lv, lr, rd);
            if (rd != 8'(8'h11 * i + 8'h3C)) errs++;
        end
        check(errs == 0, "R8 back-to-back write/read pattern", errs, 0);
        check(bad_drive == 0, "R6 no bus drive against memory", bad_drive, 0);
    endtask

    task automatic t_busy;
        int rd0, wr0, seen0;
        rd0 = rd_ops;
        wr0 = wr_ops;
        seen0 = rd_valid_seen;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 18'h00777;
        req_wdata = 8'hC3;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        // switch to a read while busy, and hold it
        req_write = 1'b0;
        req_addr  = 18'h00012;
        for (int k = 0; k < 8; k++) begin
            check(!req_ready, "R7 not ready while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(rd_ops == rd0, "R7 held request started no read", rd_ops - rd0, 0);
        check(rd_valid_seen == seen0, "R7 no read-valid from held request", rd_valid_seen - seen0, 0);
        check(wr_ops == wr0 + 1, "R7 exactly one write", wr_ops - wr0, 1);
        check(peek(18'h00777) == 8'hC3, "R8 busy-window write landed", peek(18'h00777), 8'hC3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_write_read;
        t_pulse;
        t_boundary;
        t_mixed;
        t_busy;
        check(bad_drive == 0, "R4 drive only inside write window", bad_drive, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog R7 actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule